// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Three sources feed it with single-cycle request pulses: a USB event, and the overflows of timer/counter 0 and timer/counter 1. Each pulse sets a request flag that stays set until the request is serviced or software clears it. A single byte-wide control register holds all flags, one enable per source and a master enable. The core reads and writes this register at data address 0x0B.

Requests are only acted on at a cycle-phase strobe from the core. At a strobe, a source is pending when its flag, its own enable and the master enable are all set. The highest-priority pending source wins, unless the core reports that its return stack is full. On a win, the block pulses an acknowledge together with the source index and its vector address. In the same cycle it clears the master enable and the winning flag, and it marks a service routine as running. A return-with-enable sets the master enable again. A plain return ends the service but leaves the master enable cleared, so further requests wait until software sets it.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and `irq_ack_o` and `in_service_o` are low.
- R2: The control register is reached only at address 0x0B, and its read value is combinational on `reg_addr_i`. Its bit layout is: bit 0 master enable; bits 1, 2, 3 the enables for USB, timer 0 and timer 1; bits 4, 5, 6 the request flags in the same source order; bit 7 always reads 0. A write replaces bits 6:0. Any other address reads 0x00, and writes to it have no effect.
- R3: A pulse on `src_evt_i[i]` (bit 0 USB, bit 1 timer 0, bit 2 timer 1) sets flag i from the next cycle. The flag stays set with no strobe. If a register write in the same cycle clears the flag, the event still sets it.
- R4: An acknowledge comes only from a cycle in which `phase_stb_i` is high. If, at that clock edge, some source has its flag, its enable and the master enable all set, and the stack is not full, then `irq_ack_o` is high for exactly the next cycle. A pending request without a strobe is never acknowledged.
- R5: Priority is fixed: USB over timer 0 over timer 1. With an acknowledge, `irq_idx_o` gives 0, 1 or 2, and `irq_vec_o` gives 0x04, 0x08 or 0x0C, for USB, timer 0 and timer 1.
- R6: On an acknowledge, the master enable and the winning flag are cleared, the other bits are kept, and `in_service_o` goes high.
- R7: While `stack_full_i` is high, no acknowledge is issued and the register is unchanged. The request is acknowledged at the first strobe after the input falls.
- R8: A `ret_en_i` pulse sets the master enable and clears `in_service_o`. A pending request is then acknowledged at the next strobe.
- R9: A `ret_plain_i` pulse clears `in_service_o` and leaves the master enable unchanged. With the master enable at 0, later strobes give no acknowledge.
- R10: If software sets the master enable during a service routine, a pending request is acknowledged at the next strobe, and `in_service_o` stays high.
- R11: With a cleared source enable or a cleared master enable, a set flag is never acknowledged, and it stays set in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_stb_i | input | 1 | Cycle-phase strobe; arbitration happens only in these cycles |
| src_evt_i | input | 3 | Request pulses: bit 0 USB, bit 1 timer 0, bit 2 timer 1 |
| reg_addr_i | input | 8 | Data address for register access |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_data_i | input | 8 | Register write data |
| reg_rd_data_o | output | 8 | Register read data (0 when the address does not match) |
| ret_en_i | input | 1 | Core executed return-with-enable |
| ret_plain_i | input | 1 | Core executed plain return |
| stack_full_i | input | 1 | Return stack full; blocks acknowledges |
| irq_ack_o | output | 1 | One-cycle acknowledge pulse |
| irq_idx_o | output | 2 | Index of the acknowledged source |
| irq_vec_o | output | 8 | Vector address of the acknowledged source |
| in_service_o | output | 1 | A service routine is running |

## Verification
Register reads are combinational, so the bench samples them in the same cycle it sets the address. A write or event pulse applied at one rising edge shows in the register half a cycle later. The acknowledge, index, vector, in-service bit and post-acknowledge register value all come from registers loaded at the strobe edge, so the bench checks them at the falling edge right after the strobe cycle. The acknowledge is checked again one cycle later to confirm it has dropped. A sweep covers all 128 register values, with and without a full stack. Each expected outcome is computed arithmetically from the enable and flag bits, and directed sequences cover the return and nesting cases.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    // Source ordering doubles as priority: lower index wins.
    typedef enum logic [1:0] {
        SRC_USB  = 2'd0,
        SRC_TMR0 = 2'd1,
        SRC_TMR1 = 2'd2
    } src_e;

    // Width of the packed control field for a given source count.
    function automatic int ctl_field_width(input int nsrc);
        return 2 * nsrc + 1;
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic            any_o
);

    // blk[i] is high when any higher-priority (lower index) request exists.
    logic [NSRC:0] blk;

    assign blk[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_pri
        assign grant_o[i]  = req_i[i] & ~blk[i];
        assign blk[i+1]    = blk[i] | req_i[i];
    end

    assign any_o = blk[NSRC];

endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
    parameter int NSRC     = 3,
    parameter int IW       = 2,
    parameter int VW       = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic [NSRC-1:0] grant_i,
    output logic [IW-1:0]   idx_o,
    output logic [VW-1:0]   vec_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant_i[i]) begin
                idx_o = IW'(i);
            end
        end
        vec_o = VW'(VEC_BASE) + VW'(VEC_STEP) * VW'(idx_o);
    end

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int          NSRC     = 3,
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [7:0]  REG_ADDR = 8'h0B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_en_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [DW-1:0]   rd_data_o,
    input  logic [NSRC-1:0] evt_i,
    input  logic            ret_en_i,
    input  logic            ack_i,
    input  logic [NSRC-1:0] grant_i,
    output logic            emi_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] flg_o
);

    import irq_ctrl_pkg::*;

    localparam int FW = ctl_field_width(NSRC);

    typedef struct packed {
        logic [NSRC-1:0] flg;
        logic [NSRC-1:0] en;
        logic            emi;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic addr_hit;
    logic wr_hit;

    assign addr_hit = (addr_i == AW'(REG_ADDR));
    assign wr_hit   = wr_en_i & addr_hit;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d.emi = wr_data_i[0];
            ctl_d.en  = wr_data_i[NSRC:1];
            ctl_d.flg = wr_data_i[2*NSRC:NSRC+1];
        end
        if (ret_en_i) begin
            ctl_d.emi = 1'b1;
        end
        // New events win over a software clear in the same cycle.
        ctl_d.flg = ctl_d.flg | evt_i;
        if (ack_i) begin
            ctl_d.emi = 1'b0;
            ctl_d.flg = (ctl_d.flg & ~grant_i) | evt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (addr_hit) begin
            rd_data_o = DW'(FW'(ctl_q));
        end
    end

    assign emi_o = ctl_q.emi;
    assign en_o  = ctl_q.en;
    assign flg_o = ctl_q.flg;

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((ctl_q.flg & $past(evt_i)) == $past(evt_i))); // R3

    AST_ACK_CLR_EMI: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !ctl_q.emi); // R6

    AST_RETI_SETS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en_i && !ack_i) |=> ctl_q.emi); // R8

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int          NSRC     = 3,
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter int          VW       = 8,
    parameter int          VEC_BASE = 4,
    parameter int          VEC_STEP = 4,
    parameter logic [7:0]  REG_ADDR = 8'h0B,
    localparam int         IW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase_stb_i,
    input  logic [NSRC-1:0] src_evt_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic            reg_wr_en_i,
    input  logic [DW-1:0]   reg_wr_data_i,
    output logic [DW-1:0]   reg_rd_data_o,
    input  logic            ret_en_i,
    input  logic            ret_plain_i,
    input  logic            stack_full_i,
    output logic            irq_ack_o,
    output logic [IW-1:0]   irq_idx_o,
    output logic [VW-1:0]   irq_vec_o,
    output logic            in_service_o
);

    typedef struct packed {
        logic          ack;
        logic [IW-1:0] idx;
        logic [VW-1:0] vec;
        logic          svc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            emi;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] flg;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    logic            any_pend;
    logic [IW-1:0]   enc_idx;
    logic [VW-1:0]   enc_vec;
    logic            ack_d;
    logic            wr_hit;

    irq_flag_reg #(
        .NSRC     (NSRC),
        .AW       (AW),
        .DW       (DW),
        .REG_ADDR (REG_ADDR)
    ) u_flag_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .wr_en_i   (reg_wr_en_i),
        .wr_data_i (reg_wr_data_i),
        .rd_data_o (reg_rd_data_o),
        .evt_i     (src_evt_i),
        .ret_en_i  (ret_en_i),
        .ack_i     (ack_d),
        .grant_i   (grant),
        .emi_o     (emi),
        .en_o      (en),
        .flg_o     (flg)
    );

    assign pend = flg & en & {NSRC{emi}};

    irq_arbiter #(
        .NSRC (NSRC)
    ) u_arbiter (
        .req_i   (pend),
        .grant_o (grant),
        .any_o   (any_pend)
    );

    irq_vec_enc #(
        .NSRC     (NSRC),
        .IW       (IW),
        .VW       (VW),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_vec_enc (
        .grant_i (grant),
        .idx_o   (enc_idx),
        .vec_o   (enc_vec)
    );

    assign ack_d  = phase_stb_i & any_pend & ~stack_full_i;
    assign wr_hit = reg_wr_en_i & (reg_addr_i == AW'(REG_ADDR));

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = ack_d;
        if (ack_d) begin
            seq_d.idx = enc_idx;
            seq_d.vec = enc_vec;
            seq_d.svc = 1'b1;
        end else if (ret_en_i || ret_plain_i) begin
            seq_d.svc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign irq_ack_o    = seq_q.ack;
    assign irq_idx_o    = seq_q.idx;
    assign irq_vec_o    = seq_q.vec;
    assign in_service_o = seq_q.svc;

    AST_ACK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> $past(phase_stb_i)); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o); // R4

    AST_STACK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> !$past(stack_full_i)); // R7

    AST_SVC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (in_service_o && !emi)); // R6

    AST_PLAIN_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain_i && !ret_en_i && !wr_hit && !ack_d) |=> (emi == $past(emi))); // R9

    AST_NO_MASKED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb_i && !emi) |=> !irq_ack_o); // R11

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_stb = 1'b0;
    logic [2:0] src_evt = '0;
    logic [7:0] reg_addr = 8'h0B;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       ret_en = 1'b0;
    logic       ret_plain = 1'b0;
    logic       stack_full = 1'b0;
    logic       irq_ack;
    logic [1:0] irq_idx;
    logic [7:0] irq_vec;
    logic       in_service;

    int n_chk = 0;
    int n_fail = 0;

    irq_ctrl u_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_stb_i   (phase_stb),
        .src_evt_i     (src_evt),
        .reg_addr_i    (reg_addr),
        .reg_wr_en_i   (reg_wr_en),
        .reg_wr_data_i (reg_wr_data),
        .reg_rd_data_o (reg_rd_data),
        .ret_en_i      (ret_en),
        .ret_plain_i   (ret_plain),
        .stack_full_i  (stack_full),
        .irq_ack_o     (irq_ack),
        .irq_idx_o     (irq_idx),
        .irq_vec_o     (irq_vec),
        .in_service_o  (in_service)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a;
        reg_wr_data = d;
        reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
        reg_addr = 8'h0B;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rd_data;
        reg_addr = 8'h0B;
        #1;
    endtask

    task automatic strobe();
        phase_stb = 1'b1;
        tick();
        phase_stb = 1'b0;
    endtask

    task automatic pulse_ret(input bit with_en);
        ret_en = with_en;
        ret_plain = !with_en;
        tick();
        ret_en = 1'b0;
        ret_plain = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h0B, r);
        chk("R1 reg", r, 8'h00);
        chk("R1 ack", irq_ack, 0);
        chk("R1 svc", in_service, 0);

        // R2: address decode, bit 7 reads zero
        wr(8'h0A, 8'h7F);
        rd(8'h0B, r);
        chk("R2 other addr write ignored", r, 8'h00);
        rd(8'h0A, r);
        chk("R2 other addr reads zero", r, 8'h00);
        wr(8'h0B, 8'hFE);
        rd(8'h0B, r);
        chk("R2 bit7 reads zero", r, 8'h7E);
        wr(8'h0B, 8'h00);

        // R3: events latch flags and beat a same-cycle clear
        src_evt = 3'b101;
        tick();
        src_evt = 3'b000;
        rd(8'h0B, r);
        chk("R3 flags latched", r, 8'h50);
        repeat (3) tick();
        rd(8'h0B, r);
        chk("R3 flags held", r, 8'h50);
        reg_wr_data = 8'h00;
        reg_wr_en = 1'b1;
        src_evt = 3'b010;
        tick();
        reg_wr_en = 1'b0;
        src_evt = 3'b000;
        rd(8'h0B, r);
        chk("R3 event wins over clear", r, 8'h20);
        wr(8'h0B, 8'h00);

        // R4 R5 R6 R7 R11: sweep of all register values, stack free and full
        for (int sf = 0; sf < 2; sf++) begin
            for (int v = 0; v < 128; v++) begin
                int emi_b;
                int pend;
                int w;
                int exp_ack;
                int exp_reg;
                emi_b = v & 1;
                pend = ((v >> 1) & 7) & ((v >> 4) & 7);
                if (emi_b == 0) pend = 0;
                w = 0;
                if (pend & 1) w = 0;
                else if (pend & 2) w = 1;
                else if (pend & 4) w = 2;
                exp_ack = (pend != 0 && sf == 0) ? 1 : 0;
                exp_reg = exp_ack ? (v & ~1 & ~(1 << (4 + w))) : v;
                wr(8'h0B, 8'(v));
                rd(8'h0B, r);
                chk("R2 readback", r, v);
                stack_full = sf[0];
                strobe();
                stack_full = 1'b0;
                chk(sf ? "R7 no ack when stack full" : "R4 R11 ack", irq_ack, exp_ack);
                chk("R6 in service", in_service, exp_ack);
                if (exp_ack) begin
                    chk("R5 vector", irq_vec, 4 + 4 * w);
                    chk("R5 index", irq_idx, w);
                end
                rd(8'h0B, r);
                chk(sf ? "R7 reg unchanged" : "R6 R11 reg after strobe", r, exp_reg);
                pulse_ret(1'b0);
                chk("R4 ack single cycle", irq_ack, 0);
                chk("R9 service ended", in_service, 0);
            end
        end

        // R4: no strobe, no acknowledge
        wr(8'h0B, 8'h13);
        repeat (3) begin
            tick();
            chk("R4 no ack without strobe", irq_ack, 0);
        end
        strobe();
        chk("R4 ack at strobe", irq_ack, 1);
        pulse_ret(1'b0);

        // R8 R9: return behaviour
        wr(8'h0B, 8'h3F);
        strobe();
        chk("R5 usb first", irq_vec, 8'h04);
        rd(8'h0B, r);
        chk("R6 reg after usb ack", r, 8'h2E);
        strobe();
        chk("R9 no ack while masked", irq_ack, 0);
        pulse_ret(1'b0);
        chk("R9 plain ret ends service", in_service, 0);
        rd(8'h0B, r);
        chk("R9 master stays clear", r, 8'h2E);
        strobe();
        chk("R9 no ack after plain ret", irq_ack, 0);
        pulse_ret(1'b1);
        chk("R8 ret_en ends service", in_service, 0);
        rd(8'h0B, r);
        chk("R8 master set", r, 8'h2F);
        strobe();
        chk("R8 ack after ret_en", irq_ack, 1);
        chk("R8 timer0 vector", irq_vec, 8'h08);

        // R10: nested service after software re-enable
        wr(8'h0B, 8'h4F);
        chk("R10 still in service", in_service, 1);
        strobe();
        chk("R10 nested ack", irq_ack, 1);
        chk("R10 timer1 vector", irq_vec, 8'h0C);
        chk("R10 service held", in_service, 1);
        pulse_ret(1'b1);

        // R7: request survives a full stack
        wr(8'h0B, 8'h13);
        stack_full = 1'b1;
        strobe();
        chk("R7 blocked", irq_ack, 0);
        stack_full = 1'b0;
        strobe();
        chk("R7 ack after release", irq_ack, 1);
        chk("R7 usb vector", irq_vec, 8'h04);

        finish_run();
    end

endmodule